// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches a 16-bit free-running counter that is supplied from outside, along with the prescaler tick that advances it. Software programs a 16-bit compare value as two byte registers. On a cycle where the tick is high, the counter equals the programmed value and no update is in progress, the unit counts a match. In the next cycle it copies a programmed level from its control register onto the compare output pin. That same edge sets a compare flag. The flag raises an interrupt request when the compare interrupt is enabled.

The CPU reaches the unit through a byte-wide port with a two-bit register select. The registers are the high compare byte, the low compare byte, the control byte and the status byte. Reading the status byte is the strobe that arms the flag-clearing sequence. A 16-bit value cannot be written in one access, so a write to the high byte suspends matching until the low byte follows. A pulse train on the pin is made by rewriting the level bit and the compare value after each match.

Top module: `toc_unit`

## Requirements
- R1: After reset the pin, the compare flag, the interrupt request, the level bit and the interrupt enable are all 0.
- R2: When tick is high and count_i equals the compare value, the pin and the flag update at the next rising clock edge.
- R3: While tick is low, a counter value equal to the compare value changes neither the pin nor the flag.
- R4: A match drives the pin to the level bit (control bit 0). It does not toggle the pin. Between matches the pin keeps its level.
- R5: The registers read back through rdata while rd_en is high. Select 0 is the high compare byte and select 1 the low byte. Select 2 is control: bit 0 is the level and bit 1 is the interrupt enable. Select 3 is status, with the flag in bit 0. Unused bits read 0, and rdata is 0 while rd_en is low.
- R6: The two compare byte registers keep their contents through a reset.
- R7: A write to the high compare byte suspends matching, including in the cycle of the low-byte write. Matching resumes in the cycle after the low byte is written.
- R8: The flag clears only when the status byte is read while the flag is set and the low compare byte is then written. A low-byte write without that read leaves the flag set.
- R9: irq is high exactly when the flag and the interrupt enable (control bit 1) are both set.
- R10: A match in the same cycle as the clearing low-byte write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Prescaler tick; compares are evaluated only while high |
| count_i | input | 16 | Free-running counter value |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| cmp_pin | output | 1 | Compare output pin |
| irq | output | 1 | Compare interrupt request |

## Verification
The hardest case to reach is a match that falls in the same cycle as the low-byte write that would clear the flag. It needs a set flag, an armed status read, a tick and an equal counter, all lined up on one edge. The bench reaches it by arming with a status read first. It then drives the low-byte write together with a tick and the counter held at the old compare value, so the registered compare value is still the one the counter equals. A second hard case is a high-byte write followed by ticks at both the old and the new value. That case shows that neither half-updated value produces a match.

// File: rtl/toc_pkg.sv
package toc_pkg;

  typedef enum logic [1:0] {
    TOC_SEL_HI  = 2'd0,
    TOC_SEL_LO  = 2'd1,
    TOC_SEL_CTL = 2'd2,
    TOC_SEL_STS = 2'd3
  } toc_sel_e;

  typedef struct packed {
    logic irq_en;
    logic level;
  } toc_ctl_t;

  localparam int unsigned TOC_CTL_LEVEL_BIT = 0;
  localparam int unsigned TOC_CTL_IEN_BIT   = 1;
  localparam int unsigned TOC_STS_FLAG_BIT  = 0;

endpackage

// File: rtl/toc_regs.sv
module toc_regs
  import toc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_en,
  input  toc_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_val,
  output toc_ctl_t          ctl,
  output logic              inhibit,
  output logic              lo_wr
);

  logic              hi_we;
  logic              lo_we;
  logic              ctl_we;
  logic [BYTE_W-1:0] cmp_hi_q;
  logic [BYTE_W-1:0] cmp_lo_q;
  toc_ctl_t          ctl_q;
  toc_ctl_t          ctl_d;
  logic              inh_q;
  logic              inh_d;

  // write decode
  always_comb begin
    hi_we  = wr_en && (sel == TOC_SEL_HI);
    lo_we  = wr_en && (sel == TOC_SEL_LO);
    ctl_we = wr_en && (sel == TOC_SEL_CTL);
  end

  // compare bytes: no reset, clock-enabled
  always_ff @(posedge clk) begin
    if (hi_we) begin
      cmp_hi_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_we) begin
      cmp_lo_q <= wdata;
    end
  end

  // control and inhibit next state
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.level  = wdata[TOC_CTL_LEVEL_BIT];
      ctl_d.irq_en = wdata[TOC_CTL_IEN_BIT];
    end
    inh_d = inh_q;
    if (hi_we) begin
      inh_d = 1'b1;
    end else if (lo_we) begin
      inh_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctl_q <= '0;
      inh_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      inh_q <= inh_d;
    end
  end

  assign cmp_val = {cmp_hi_q, cmp_lo_q};
  assign ctl     = ctl_q;
  assign inhibit = inh_q;
  assign lo_wr   = lo_we;

endmodule

// File: rtl/toc_match.sv
module toc_match #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2,
  localparam int unsigned CNT_W = NBYTES * BYTE_W
) (
  input  logic             tick,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             hit
);

  logic [NBYTES-1:0] byte_eq;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_eq[b] = (count[b*BYTE_W +: BYTE_W] == cmp_val[b*BYTE_W +: BYTE_W]);
  end

  always_comb begin
    hit = tick && !inhibit && (&byte_eq);
  end

endmodule

// File: rtl/toc_flag.sv
module toc_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic hit,
  input  logic sts_rd,
  input  logic lo_wr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  logic flag_q;
  logic flag_d;
  logic arm_q;
  logic arm_d;

  always_comb begin
    flag_d = flag_q;
    if (hit) begin
      flag_d = 1'b1;
    end else if (arm_q && lo_wr) begin
      flag_d = 1'b0;
    end

    arm_d = arm_q;
    if (sts_rd && flag_q) begin
      arm_d = 1'b1;
    end
    if (lo_wr || !flag_d) begin
      arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q && irq_en;

endmodule

// File: rtl/toc_pin.sv
module toc_pin (
  input  logic clk,
  input  logic rst_sn,
  input  logic hit,
  input  logic level,
  output logic pin
);

  logic pin_q;
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    if (hit) begin
      pin_d = level;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

  assign pin = pin_q;

endmodule

// File: rtl/toc_unit.sv
module toc_unit
  import toc_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned NBYTES   = 2,
  localparam int unsigned CNT_W    = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              cmp_pin,
  output logic              irq
);

  logic [SYNC_DEPTH-1:0] rst_pipe_q;
  logic                  rst_sn;
  toc_sel_e              sel;
  logic [CNT_W-1:0]      cmp_val;
  toc_ctl_t              ctl;
  logic                  inhibit;
  logic                  lo_wr;
  logic                  hit;
  logic                  sts_rd;
  logic                  flag;
  logic [BYTE_W-1:0]     rd_mux;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_DEPTH-2:0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe_q[SYNC_DEPTH-1];

  assign sel    = toc_sel_e'(addr);
  assign sts_rd = rd_en && (sel == TOC_SEL_STS);

  toc_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .wr_en   (wr_en),
    .sel     (sel),
    .wdata   (wdata),
    .cmp_val (cmp_val),
    .ctl     (ctl),
    .inhibit (inhibit),
    .lo_wr   (lo_wr)
  );

  toc_match #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_match (
    .tick    (tick),
    .inhibit (inhibit),
    .count   (count_i),
    .cmp_val (cmp_val),
    .hit     (hit)
  );

  toc_flag u_flag (
    .clk    (clk),
    .rst_sn (rst_sn),
    .hit    (hit),
    .sts_rd (sts_rd),
    .lo_wr  (lo_wr),
    .irq_en (ctl.irq_en),
    .flag   (flag),
    .irq    (irq)
  );

  toc_pin u_pin (
    .clk    (clk),
    .rst_sn (rst_sn),
    .hit    (hit),
    .level  (ctl.level),
    .pin    (cmp_pin)
  );

  // read mux
  always_comb begin
    rd_mux = '0;
    case (sel)
      TOC_SEL_HI:  rd_mux = cmp_val[CNT_W-1 -: BYTE_W];
      TOC_SEL_LO:  rd_mux = cmp_val[BYTE_W-1:0];
      TOC_SEL_CTL: begin
        rd_mux[TOC_CTL_LEVEL_BIT] = ctl.level;
        rd_mux[TOC_CTL_IEN_BIT]   = ctl.irq_en;
      end
      TOC_SEL_STS: rd_mux[TOC_STS_FLAG_BIT] = flag;
      default:     rd_mux = '0;
    endcase
    rdata = rd_en ? rd_mux : '0;
  end

endmodule

// File: rtl/toc_unit_chk.sv
module toc_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             tick,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] cmp_val,
  input logic             inhibit,
  input logic             level,
  input logic             irq_en,
  input logic             lo_wr,
  input logic             flag,
  input logic             cmp_pin,
  input logic             irq
);

  // R3: no tick, no change on the pin and no new flag
  assert_quiet_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick |=> ($stable(cmp_pin) && !$rose(flag)));

  // R2, R4: a ticked match copies the level and sets the flag
  assert_match_transfer_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && !inhibit && (count_i == cmp_val)) |=> (flag && (cmp_pin == $past(level))));

  // R7: an inhibited cycle cannot move the pin
  assert_inhibit_hold_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    inhibit |=> $stable(cmp_pin));

  // R8: flag only falls after a low-byte write
  assert_flag_clear_path_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(flag) |-> $past(lo_wr));

  // R9: request never without the flag and enable
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> (flag && irq_en));

  // R10: a match wins over a concurrent clear
  assert_set_priority_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (lo_wr && tick && !inhibit && (count_i == cmp_val)) |=> flag);

endmodule

bind toc_unit toc_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .tick    (tick),
  .count_i (count_i),
  .cmp_val (cmp_val),
  .inhibit (inhibit),
  .level   (ctl.level),
  .irq_en  (ctl.irq_en),
  .lo_wr   (lo_wr),
  .flag    (flag),
  .cmp_pin (cmp_pin),
  .irq     (irq)
);

// File: tb/test_toc_unit.sv
module test_toc_unit;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [15:0] count_i;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        cmp_pin;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [1:0] A_HI = 2'd0, A_LO = 2'd1, A_CTL = 2'd2, A_STS = 2'd3;

  toc_unit i_toc_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .count_i (count_i),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .cmp_pin (cmp_pin),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] c);
    @(negedge clk);
    count_i = c; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clr_flag(input logic [7:0] lo);
    logic [7:0] d;
    bus_rd(A_STS, d);
    bus_wr(A_LO, lo);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(cmp_pin == 1'b0, "R1", "pin after reset", cmp_pin, 0);
    check(irq == 1'b0, "R1", "irq after reset", irq, 0);
    bus_rd(A_CTL, d);
    check(d == 8'h00, "R1", "control after reset", d, 0);
    bus_rd(A_STS, d);
    check(d == 8'h00, "R1", "status after reset", d, 0);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    bus_wr(A_HI, 8'hA5);
    bus_wr(A_LO, 8'h3C);
    bus_wr(A_CTL, 8'hFF);
    bus_rd(A_HI, d);
    check(d == 8'hA5, "R5", "high byte readback", d, 8'hA5);
    bus_rd(A_LO, d);
    check(d == 8'h3C, "R5", "low byte readback", d, 8'h3C);
    bus_rd(A_CTL, d);
    check(d == 8'h03, "R5", "control readback", d, 8'h03);
    @(negedge clk);
    addr = A_HI;
    #1 check(rdata == 8'h00, "R5", "rdata idle", rdata, 0);
    bus_wr(A_CTL, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] d;
    bus_wr(A_HI, 8'h12);
    bus_wr(A_LO, 8'h34);
    bus_wr(A_CTL, 8'h01);
    pulse(16'h1233);
    check(cmp_pin == 1'b0, "R2", "pin on non-match", cmp_pin, 0);
    bus_rd(A_STS, d);
    check(d == 8'h00, "R2", "flag on non-match", d, 0);
    pulse(16'h1234);
    check(cmp_pin == 1'b1, "R2", "pin on match", cmp_pin, 1);
    bus_rd(A_STS, d);
    check(d == 8'h01, "R2", "flag on match", d, 1);
  endtask

  task automatic t_no_tick_and_level();
    logic [7:0] d;
    clr_flag(8'h34);
    bus_wr(A_CTL, 8'h00);
    @(negedge clk);
    count_i = 16'h1234; tick = 1'b0;
    repeat (3) @(negedge clk);
    check(cmp_pin == 1'b1, "R3", "pin with no tick", cmp_pin, 1);
    bus_rd(A_STS, d);
    check(d == 8'h00, "R3", "flag with no tick", d, 0);
    pulse(16'h1234);
    check(cmp_pin == 1'b0, "R4", "pin takes level 0", cmp_pin, 0);
    pulse(16'h1234);
    check(cmp_pin == 1'b0, "R4", "repeat match no toggle", cmp_pin, 0);
    pulse(16'h0001);
    check(cmp_pin == 1'b0, "R4", "pin holds between matches", cmp_pin, 0);
  endtask

  task automatic t_flag_clear();
    logic [7:0] d;
    bus_wr(A_LO, 8'h34);
    bus_rd(A_STS, d);
    check(d == 8'h01, "R8", "flag kept without status read", d, 1);
    bus_wr(A_LO, 8'h34);
    bus_rd(A_STS, d);
    check(d == 8'h00, "R8", "flag cleared by sequence", d, 0);
  endtask

  task automatic t_irq();
    bus_wr(A_CTL, 8'h02);
    check(irq == 1'b0, "R9", "irq without flag", irq, 0);
    pulse(16'h1234);
    check(irq == 1'b1, "R9", "irq with flag and enable", irq, 1);
    bus_wr(A_CTL, 8'h00);
    check(irq == 1'b0, "R9", "irq with enable off", irq, 0);
    clr_flag(8'h34);
  endtask

  task automatic t_inhibit();
    logic [7:0] d;
    bus_wr(A_CTL, 8'h01);
    bus_wr(A_HI, 8'h56);
    pulse(16'h5634);
    pulse(16'h1234);
    check(cmp_pin == 1'b0, "R7", "pin during inhibit", cmp_pin, 0);
    bus_rd(A_STS, d);
    check(d == 8'h00, "R7", "flag during inhibit", d, 0);
    @(negedge clk);
    wr_en = 1'b1; addr = A_LO; wdata = 8'h78;
    count_i = 16'h5634; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    check(cmp_pin == 1'b0, "R7", "pin in low-write cycle", cmp_pin, 0);
    pulse(16'h5678);
    check(cmp_pin == 1'b1, "R7", "pin after low write", cmp_pin, 1);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    bus_rd(A_STS, d);
    check(d == 8'h01, "R10", "flag before race", d, 1);
    @(negedge clk);
    wr_en = 1'b1; addr = A_LO; wdata = 8'h78;
    count_i = 16'h5678; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    bus_rd(A_STS, d);
    check(d == 8'h01, "R10", "match beats clear", d, 1);
  endtask

  task automatic t_reset_keep();
    logic [7:0] d;
    do_reset();
    check(cmp_pin == 1'b0, "R1", "pin after second reset", cmp_pin, 0);
    bus_rd(A_HI, d);
    check(d == 8'h56, "R6", "high byte kept", d, 8'h56);
    bus_rd(A_LO, d);
    check(d == 8'h78, "R6", "low byte kept", d, 8'h78);
    bus_rd(A_STS, d);
    check(d == 8'h00, "R1", "flag after second reset", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; count_i = '0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_match();
    t_no_tick_and_level();
    t_flag_clear();
    t_irq();
    t_inhibit();
    t_set_wins();
    t_reset_keep();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule